// File: doc/BRIEF.md
# Interrupt Condition and Mask Unit

This block holds the 64-bit status word of a two-wire bus controller, turns it into an interrupt condition vector, and combines that vector with a software-owned mask. It drives a single level-sensitive interrupt line. The host reaches it through 64-bit register accesses only. The register offset is the byte address shifted right by three.

The status word collects two kinds of input. Error events from the surrounding controller are sticky. Live fields are loaded whenever the controller strobes an update. The raw condition is the status word shifted right by sixteen positions. The masked condition is the raw condition ANDed with the mask.

Two offsets behave differently for reads and writes. A read returns one of the condition vectors, while a write edits the mask: one offset ORs bits into it and the other ANDs it down. A write to the status offset performs a full soft reset. A write to the extended-status offset clears only the error bits.

Top module: `intr_cond_unit`

## Requirements
- R1: After reset, the status word is 0x01000C0000000000 for one port. That value has command-done (LSB index 56), SCL level (43) and SDA level (42) set, plus a threshold field at indices 54:48 equal to NUM_PORTS-1. After reset the mask is zero, `irq_o` is low, and the extended status reads 0x0800000000000017: FIFO depth 8 in indices 63:56 and version 23 in indices 4:0.
- R2: The register offset is `acc_addr_i >> 3`, and address bits 2:0 are ignored. `acc_rdata_o` is combinational during a read request and shows the state before the access takes effect. It is zero when no read is requested.
- R3: A read at offset 0x9 returns the status word logically shifted right by 16.
- R4: A read at offset 0xA returns the raw condition AND the mask. `irq_o` is high exactly when that value is non-zero, and it follows the state registered at the preceding clock edge.
- R5: A read at offset 0x8 returns the mask, and a write at offset 0x8 replaces the mask with the write data.
- R6: A write at offset 0x9 ORs the write data into the mask.
- R7: A write at offset 0xA ANDs the write data into the mask.
- R8: The error event bits in `err_evt_i` map to status indices as follows: [0] invalid command (63), [1] parity (62), [2] overrun (61), [3] access (60), [4] arbitration lost (59), [5] NACK (58), [6] stop error (55). Each sets its status bit on the next edge, and the bit stays set until a soft reset or an error clear.
- R9: A write at offset 0xC clears all seven error bits and leaves the other status fields unchanged. An error event in the same cycle still sets its bit. A read at offset 0xC returns the constant extended status.
- R10: A write at offset 0xB restores the status word and the mask to their reset values. A read at offset 0xB returns the status word.
- R11: A read or write at any offset outside 0x8 to 0xC sets the invalid-command status bit (index 63). Such a read returns all ones.
- R12: When `live_upd_i` is high and no soft reset is written in that cycle, the status word loads several live fields: data request (57), command done (56), SCL (43), SDA (42), interface busy (40) and FIFO count (39:32). No other bit changes because of the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_req_i | input | 1 | Register access request, one cycle per access |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | ADDR_W | Byte address of the access |
| acc_wdata_i | input | 64 | Write data |
| acc_rdata_o | output | 64 | Read data, valid in the request cycle |
| err_evt_i | input | 7 | Error event pulses, mapped as in R8 |
| live_upd_i | input | 1 | Load strobe for the live status fields |
| live_dreq_i | input | 1 | Live data-request level |
| live_cdone_i | input | 1 | Live command-done level |
| live_scl_i | input | 1 | Live SCL input level |
| live_sda_i | input | 1 | Live SDA input level |
| live_busy_i | input | 1 | Live interface-busy level |
| live_fcnt_i | input | 8 | Live FIFO entry count |
| irq_o | output | 1 | Level interrupt, high when the masked condition is non-zero |

## Verification
The hardest situation to create is a collision within a single cycle. Examples are an error clear or an unimplemented access landing together with error events and a live update, or a mask OR/AND edit landing just as the raw condition changes under it. Only in such cycles do the update priorities decide the result. The stimulus mixes a directed sequence with random cycles that drive events, live updates and register accesses together. A bench model, written from the requirements, predicts every read and the interrupt level after each edge.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int DW = 64;

  // register offsets (byte address >> 3)
  localparam int OFS_MASK     = 8;
  localparam int OFS_OR_RAW   = 9;
  localparam int OFS_AND_COND = 10;
  localparam int OFS_STAT     = 11;
  localparam int OFS_EXT      = 12;

  // status word bit indices (LSB numbering)
  localparam int ST_INVALID = 63;
  localparam int ST_PARITY  = 62;
  localparam int ST_OVERRUN = 61;
  localparam int ST_ACCESS  = 60;
  localparam int ST_ARB     = 59;
  localparam int ST_NACK    = 58;
  localparam int ST_DREQ    = 57;
  localparam int ST_CDONE   = 56;
  localparam int ST_STOP    = 55;
  localparam int ST_THR_HI  = 54;
  localparam int ST_THR_LO  = 48;
  localparam int ST_SCL     = 43;
  localparam int ST_SDA     = 42;
  localparam int ST_BUSY    = 40;
  localparam int ST_FC_HI   = 39;
  localparam int ST_FC_LO   = 32;

  localparam logic [DW-1:0] ERR_BITS =
    (64'd1 << ST_INVALID) | (64'd1 << ST_PARITY) | (64'd1 << ST_OVERRUN) |
    (64'd1 << ST_ACCESS)  | (64'd1 << ST_ARB)    | (64'd1 << ST_NACK)    |
    (64'd1 << ST_STOP);

  function automatic logic [DW-1:0] status_rst(int nports);
    logic [DW-1:0] v;
    v = '0;
    v[ST_CDONE] = 1'b1;
    v[ST_SCL]   = 1'b1;
    v[ST_SDA]   = 1'b1;
    v[ST_THR_HI:ST_THR_LO] = 7'(nports - 1);
    return v;
  endfunction

  function automatic logic [DW-1:0] ext_status(int depth, int version);
    logic [DW-1:0] v;
    v = '0;
    v[63:56] = 8'(depth);
    v[4:0]   = 5'(version);
    return v;
  endfunction

  function automatic logic [DW-1:0] err_to_status(logic [6:0] e);
    logic [DW-1:0] v;
    v = '0;
    v[ST_INVALID] = e[0];
    v[ST_PARITY]  = e[1];
    v[ST_OVERRUN] = e[2];
    v[ST_ACCESS]  = e[3];
    v[ST_ARB]     = e[4];
    v[ST_NACK]    = e[5];
    v[ST_STOP]    = e[6];
    return v;
  endfunction

  function automatic logic [DW-1:0] raw_of(logic [DW-1:0] st);
    return st >> 16;
  endfunction
endpackage

// File: rtl/icu_decode.sv
module icu_decode #(
  parameter int ADDR_W = 12
) (
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [4:0]        sel_o,
  output logic              wr_mask_o,
  output logic              wr_or_o,
  output logic              wr_and_o,
  output logic              wr_srst_o,
  output logic              wr_eclr_o,
  output logic              bad_o
);
  import icu_pkg::*;
  localparam int OW = ADDR_W - 3;

  logic [OW-1:0] ofs;
  logic          hit;
  logic          unused_lsb;

  assign ofs        = addr_i[ADDR_W-1:3];
  assign unused_lsb = ^addr_i[2:0];

  always_comb begin
    hit   = 1'b0;
    sel_o = '0;
    for (int k = OFS_MASK; k <= OFS_EXT; k++) begin
      if (ofs == OW'(k)) begin
        hit   = 1'b1;
        sel_o = 5'(k);
      end
    end
  end

  assign wr_mask_o = req_i && wr_i && hit && (sel_o == 5'(OFS_MASK));
  assign wr_or_o   = req_i && wr_i && hit && (sel_o == 5'(OFS_OR_RAW));
  assign wr_and_o  = req_i && wr_i && hit && (sel_o == 5'(OFS_AND_COND));
  assign wr_srst_o = req_i && wr_i && hit && (sel_o == 5'(OFS_STAT));
  assign wr_eclr_o = req_i && wr_i && hit && (sel_o == 5'(OFS_EXT));
  assign bad_o     = req_i && !hit;

  // R2
  always_comb begin
    strobe_onehot_chk: assert ($onehot0({wr_mask_o, wr_or_o, wr_and_o, wr_srst_o, wr_eclr_o, bad_o}));
  end
endmodule

// File: rtl/icu_status.sv
module icu_status #(
  parameter int NUM_PORTS = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        srst_i,
  input  logic        eclr_i,
  input  logic        bad_i,
  input  logic [6:0]  evt_i,
  input  logic        upd_i,
  input  logic        dreq_i,
  input  logic        cdone_i,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic        busy_i,
  input  logic [7:0]  fcnt_i,
  output logic [63:0] status_o
);
  import icu_pkg::*;
  localparam logic [DW-1:0] RST_VAL = status_rst(NUM_PORTS);

  logic [DW-1:0] status_q, base_w, err_set_w, nxt;

  assign err_set_w = err_to_status(evt_i) | ({63'd0, bad_i} << ST_INVALID);

  always_comb begin
    base_w = status_q;
    if (srst_i) begin
      base_w = RST_VAL;
    end else begin
      if (eclr_i) base_w = base_w & ~ERR_BITS;
      if (upd_i) begin
        base_w[ST_DREQ]           = dreq_i;
        base_w[ST_CDONE]          = cdone_i;
        base_w[ST_SCL]            = scl_i;
        base_w[ST_SDA]            = sda_i;
        base_w[ST_BUSY]           = busy_i;
        base_w[ST_FC_HI:ST_FC_LO] = fcnt_i;
      end
    end
    nxt = base_w | err_set_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= RST_VAL;
    else        status_q <= nxt;
  end

  assign status_o = status_q;

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst_i && !eclr_i) |=> ((status_q & $past(status_q) & ERR_BITS) == ($past(status_q) & ERR_BITS)));
  // R9
  eclr_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eclr_i && !upd_i) |=> ((status_q & ~ERR_BITS) == ($past(status_q) & ~ERR_BITS)));
  // R10
  srst_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_i && evt_i == 7'd0) |=> (status_q == RST_VAL));
  // R11
  bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_i |=> status_q[ST_INVALID]);
endmodule

// File: rtl/icu_mask.sv
module icu_mask (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_mask_i,
  input  logic        wr_or_i,
  input  logic        wr_and_i,
  input  logic        srst_i,
  input  logic [63:0] wdata_i,
  input  logic [63:0] status_i,
  output logic [63:0] mask_o,
  output logic [63:0] raw_o,
  output logic [63:0] cond_o,
  output logic        irq_o
);
  import icu_pkg::*;

  logic [DW-1:0] mask_q, mask_nxt;
  logic          mask_edit_w;

  assign mask_edit_w = wr_mask_i | wr_or_i | wr_and_i | srst_i;

  always_comb begin
    mask_nxt = mask_q;
    if (srst_i)    mask_nxt = '0;
    if (wr_mask_i) mask_nxt = wdata_i;
    if (wr_or_i)   mask_nxt = mask_q | wdata_i;
    if (wr_and_i)  mask_nxt = mask_q & wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_nxt;
  end

  assign mask_o = mask_q;
  assign raw_o  = raw_of(status_i);
  assign cond_o = raw_o & mask_q;
  assign irq_o  = |cond_o;

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask_i |=> (mask_q == $past(wdata_i)));
  // R6
  mask_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_or_i |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
  // R7
  mask_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_and_i |=> ((mask_q & ~$past(wdata_i)) == 64'd0));
  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_edit_w |=> $stable(mask_q));
endmodule

// File: rtl/intr_cond_unit.sv
module intr_cond_unit #(
  parameter int NUM_PORTS  = 1,
  parameter int FIFO_DEPTH = 8,
  parameter int VERSION    = 23,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req_i,
  input  logic              acc_wr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [63:0]       acc_wdata_i,
  output logic [63:0]       acc_rdata_o,
  input  logic [6:0]        err_evt_i,
  input  logic              live_upd_i,
  input  logic              live_dreq_i,
  input  logic              live_cdone_i,
  input  logic              live_scl_i,
  input  logic              live_sda_i,
  input  logic              live_busy_i,
  input  logic [7:0]        live_fcnt_i,
  output logic              irq_o
);
  import icu_pkg::*;
  localparam logic [DW-1:0] EXT_VAL = ext_status(FIFO_DEPTH, VERSION);

  logic [4:0]    sel;
  logic          wr_mask, wr_or, wr_and, wr_srst, wr_eclr, bad;
  logic [DW-1:0] status_w, mask_w, raw_w, cond_w;

  icu_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_i(acc_req_i), .wr_i(acc_wr_i), .addr_i(acc_addr_i), .sel_o(sel),
    .wr_mask_o(wr_mask), .wr_or_o(wr_or), .wr_and_o(wr_and),
    .wr_srst_o(wr_srst), .wr_eclr_o(wr_eclr), .bad_o(bad)
  );

  icu_status #(.NUM_PORTS(NUM_PORTS)) u_stat (
    .clk(clk), .rst_n(rst_n), .srst_i(wr_srst), .eclr_i(wr_eclr), .bad_i(bad),
    .evt_i(err_evt_i), .upd_i(live_upd_i), .dreq_i(live_dreq_i),
    .cdone_i(live_cdone_i), .scl_i(live_scl_i), .sda_i(live_sda_i),
    .busy_i(live_busy_i), .fcnt_i(live_fcnt_i), .status_o(status_w)
  );

  icu_mask u_mask (
    .clk(clk), .rst_n(rst_n), .wr_mask_i(wr_mask), .wr_or_i(wr_or),
    .wr_and_i(wr_and), .srst_i(wr_srst), .wdata_i(acc_wdata_i),
    .status_i(status_w), .mask_o(mask_w), .raw_o(raw_w), .cond_o(cond_w),
    .irq_o(irq_o)
  );

  always_comb begin
    acc_rdata_o = '0;
    if (acc_req_i && !acc_wr_i) begin
      if (bad) acc_rdata_o = '1;
      else begin
        case (sel)
          5'(OFS_MASK):     acc_rdata_o = mask_w;
          5'(OFS_OR_RAW):   acc_rdata_o = raw_w;
          5'(OFS_AND_COND): acc_rdata_o = cond_w;
          5'(OFS_STAT):     acc_rdata_o = status_w;
          5'(OFS_EXT):      acc_rdata_o = EXT_VAL;
          default:          acc_rdata_o = '1;
        endcase
      end
    end
  end

  // R4
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((status_w >> 16) != 64'd0 && mask_w != 64'd0));
  // R2
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req_i |-> (acc_rdata_o == 64'd0));
endmodule

// File: tb/intr_cond_unit_tb_top.sv
module intr_cond_unit_tb_top;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 12;
  localparam logic [63:0] RST_ST  = 64'h01000C0000000000;
  localparam logic [63:0] EXT_ST  = 64'h0800000000000017;
  localparam logic [63:0] ERRMASK = 64'hFC80000000000000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_req = 0, acc_wr = 0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [63:0] acc_wdata = '0, acc_rdata;
  logic [6:0] evt = '0;
  logic upd = 0, l_dreq = 0, l_cdone = 0, l_scl = 0, l_sda = 0, l_busy = 0;
  logic [7:0] l_fcnt = '0;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit  done = 0;
  logic [63:0] m_st = RST_ST, m_mask = '0;

  always #(CLK_P/2) clk = ~clk;

  intr_cond_unit #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_req_i(acc_req), .acc_wr_i(acc_wr),
    .acc_addr_i(acc_addr), .acc_wdata_i(acc_wdata), .acc_rdata_o(acc_rdata),
    .err_evt_i(evt), .live_upd_i(upd), .live_dreq_i(l_dreq),
    .live_cdone_i(l_cdone), .live_scl_i(l_scl), .live_sda_i(l_sda),
    .live_busy_i(l_busy), .live_fcnt_i(l_fcnt), .irq_o(irq)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] evt_bits(logic [6:0] e);
    logic [63:0] v = '0;
    v[63] = e[0]; v[62] = e[1]; v[61] = e[2]; v[60] = e[3];
    v[59] = e[4]; v[58] = e[5]; v[55] = e[6];
    return v;
  endfunction

  function automatic logic [63:0] exp_read(int ofs);
    case (ofs)
      8:  return m_mask;
      9:  return m_st >> 16;
      10: return (m_st >> 16) & m_mask;
      11: return m_st;
      12: return EXT_ST;
      default: return '1;
    endcase
  endfunction

  function automatic void model_edge(bit rq, bit w, int ofs, logic [63:0] wd);
    bit ok = (ofs >= 8 && ofs <= 12);
    logic [63:0] s = m_st;
    if (rq && w && ofs == 8)  m_mask = wd;
    if (rq && w && ofs == 9)  m_mask = m_mask | wd;
    if (rq && w && ofs == 10) m_mask = m_mask & wd;
    if (rq && w && ofs == 11) begin m_mask = '0; s = RST_ST; end
    else begin
      if (rq && w && ofs == 12) s = s & ~ERRMASK;
      if (upd) begin
        s[57] = l_dreq; s[56] = l_cdone; s[43] = l_scl; s[42] = l_sda;
        s[40] = l_busy; s[39:32] = l_fcnt;
      end
    end
    s = s | evt_bits(evt);
    if (rq && !ok) s[63] = 1'b1;
    m_st = s;
  endfunction

  // one access cycle: drive at negedge, check read before the edge, update model
  task automatic cyc(string tag, bit rq, bit w, logic [ADDR_W-1:0] a, logic [63:0] wd);
    int ofs = int'(a >> 3);
    @(negedge clk);
    acc_req = rq; acc_wr = w; acc_addr = a; acc_wdata = wd;
    #1;
    if (rq && !w) chk({tag, " R2 read"}, acc_rdata, exp_read(ofs));
    @(posedge clk);
    model_edge(rq, w, ofs, wd);
    #1;
    acc_req = 0; acc_wr = 0; evt = '0; upd = 0;
    chk({tag, " R4 irq"}, {63'd0, irq}, {63'd0, ((m_st >> 16) & m_mask) != 0});
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset values
    chk("R1 irq", {63'd0, irq}, 64'd0);
    cyc("R1", 1, 0, 12'h058, 0);
    chk("R1 status", m_st, RST_ST);
    cyc("R1 mask", 1, 0, 12'h040, 0);
    cyc("R1 ext", 1, 0, 12'h060, 0);
    // R2 low address bits ignored
    cyc("R2", 1, 0, 12'h05D, 0);
    // R3 raw
    cyc("R3", 1, 0, 12'h04F, 0);
    // R5 load mask onto command-done raw bit 40
    cyc("R5", 1, 1, 12'h040, 64'd1 << 40);
    chk("R5 irq", {63'd0, irq}, 64'd1);
    cyc("R4", 1, 0, 12'h050, 0);
    // R7 AND clears
    cyc("R7", 1, 1, 12'h050, 64'h0);
    chk("R7 irq", {63'd0, irq}, 64'd0);
    // R6 OR sets
    cyc("R6", 1, 1, 12'h048, 64'h0000_0000_0000_8000);
    cyc("R6", 1, 1, 12'h048, 64'h0000_0000_0000_0001);
    cyc("R6", 1, 0, 12'h040, 0);
    // R8 error events; NACK (58) -> raw bit 42
    evt = 7'b010_0000;
    cyc("R8", 0, 0, 0, 0);
    cyc("R8", 1, 1, 12'h048, 64'd1 << 42);
    chk("R8 irq", {63'd0, irq}, 64'd1);
    cyc("R8 sticky", 1, 0, 12'h058, 0);
    // R9 clear with same-cycle stop event
    evt = 7'b100_0000;
    cyc("R9", 1, 1, 12'h060, 0);
    cyc("R9", 1, 0, 12'h058, 0);
    chk("R9 stop kept", {63'd0, m_st[55]}, 64'd1);
    // R11 unimplemented offsets
    cyc("R11", 1, 0, 12'h020, 0);
    cyc("R11", 1, 1, 12'h0F8, 64'hFFFF);
    cyc("R11", 1, 0, 12'h058, 0);
    // R12 live update
    upd = 1; l_dreq = 1; l_cdone = 0; l_scl = 0; l_sda = 1; l_busy = 1; l_fcnt = 8'h5A;
    cyc("R12", 0, 0, 0, 0);
    cyc("R12", 1, 0, 12'h058, 0);
    // R10 soft reset
    cyc("R10", 1, 1, 12'h058, 64'h1234);
    cyc("R10", 1, 0, 12'h058, 0);
    cyc("R10", 1, 0, 12'h040, 0);
    // random mix
    for (int i = 0; i < 1500; i++) begin
      int r = $urandom_range(0, 99);
      logic [ADDR_W-1:0] a = ADDR_W'($urandom_range(0, 16) << 3) | ADDR_W'($urandom_range(0, 7));
      logic [63:0] wd = {$urandom, $urandom};
      if ($urandom_range(0, 9) == 0) evt = 7'($urandom);
      if ($urandom_range(0, 5) == 0) begin
        upd = 1; l_dreq = 1'($urandom); l_cdone = 1'($urandom); l_scl = 1'($urandom);
        l_sda = 1'($urandom); l_busy = 1'($urandom); l_fcnt = 8'($urandom);
      end
      if ((a >> 3) == 11 && r < 40 && $urandom_range(0, 7) != 0) r = 50;
      if ($urandom_range(0, 3) == 0) wd = wd & {$urandom, $urandom};
      if (r < 40)      cyc("rnd R5 R6 R7 R10 R11", 1, 1, a, wd);
      else if (r < 90) cyc("rnd R3 R4 R9", 1, 0, a, 0);
      else             cyc("rnd R8 R12", 0, 0, 0, 0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule